// File: doc/BRIEF.md
# Interrupt Pin Request Tracker

This block keeps the request state of every input pin of an interrupt router. Each pin has its own settings: a polarity bit, a trigger type (edge or level), a mask bit and a vector. The block XORs the raw pin level with the polarity bit, keeps a request bit for each pin, and decides which pin to service. Servicing an unmasked pin raises a delivery request toward the destination logic. That logic answers in the same cycle with an acknowledge when the interrupt was accepted.

Edge pins and level pins share one request register but clear it differently. An edge pin records a rising effective edge, and servicing drops the record whether or not anything was delivered. A level pin's request bit follows the effective level. After an accepted delivery, a level pin holds a remote-pending flag. The flag blocks further delivery until an end-of-interrupt with the same vector arrives, or until the register block asks to re-service the pin. When several pins want service at once, the lowest index wins, and at most one request is issued per cycle.

Top module: `irq_pin_tracker`

## Requirements
- R1: While reset is asserted and right after it ends, `irr_o` and `remote_o` are all zero and `req_valid_o` is low.
- R2: The effective level of a pin is `level_i` XOR `polarity_i`. For a level pin (`lvl_trig_i` = 1), the `irr_o` bit equals the effective level sampled at the previous clock edge.
- R3: For an edge pin (`lvl_trig_i` = 0), `irr_o` becomes 1 one cycle after the effective level rises from 0 to 1. A level that stays high does not set the bit again once it has been cleared.
- R4: An edge pin that holds its request bit is serviced, and its `irr_o` bit is 0 in the next cycle. This applies when the pin is requested, with or without `deliv_ack_i`. It also applies when the pin is masked, in which case no request is issued.
- R5: A pin whose `mask_i` bit is 1 is never presented on `req_valid_o`/`req_pin_o`. A masked pin's remote-pending flag keeps its value.
- R6: A level pin is requested while its request bit is 1, it is unmasked, and its remote-pending flag is 0. If `deliv_ack_i` is high in a cycle where that pin is requested, its `remote_o` bit is 1 from the next cycle, and the request stops.
- R7: A level pin that is requested without `deliv_ack_i` stays requested in the following cycle, and its remote-pending flag stays 0.
- R8: When `eoi_valid_i` is high, every level pin whose vector equals `eoi_vector_i` has its remote-pending flag cleared in the next cycle. Pins with other vectors keep their flags. An edge pin never holds a remote-pending flag.
- R9: A high `reservice_i` bit clears that pin's remote-pending flag in the next cycle. The pin is then requested again if its request bit is set and it is unmasked.
- R10: `req_pin_o` is the lowest-index pin that wants service, and `req_vector_o` is that pin's vector (bits [8p+7:8p] of `vector_i` for pin p at the default width).
- R11: An effective low level clears the pin's request bit in the next cycle, for both trigger types.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | N_PINS | Raw pin levels |
| polarity_i | input | N_PINS | Per-pin inversion of the raw level |
| lvl_trig_i | input | N_PINS | Per-pin trigger type, 1 = level, 0 = edge |
| mask_i | input | N_PINS | Per-pin mask, 1 = masked |
| vector_i | input | N_PINS*VEC_W | Per-pin vector, pin p in bits [p*VEC_W +: VEC_W] |
| reservice_i | input | N_PINS | Clear remote-pending and re-evaluate the pin |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | VEC_W | Vector carried by the end-of-interrupt |
| deliv_ack_i | input | 1 | Destination accepted the current request |
| req_valid_o | output | 1 | A delivery request is presented |
| req_pin_o | output | $clog2(N_PINS) | Index of the requested pin |
| req_vector_o | output | VEC_W | Vector of the requested pin |
| irr_o | output | N_PINS | Request bits |
| remote_o | output | N_PINS | Remote-pending flags |

## Verification
The hardest case to reach is an end-of-interrupt whose vector is shared by several pins of different types. The stimulus has to give one level pin a remote-pending flag, keep another level pin with the same vector masked while it also holds a flag, and keep an edge pin with that vector busy, all before the strobe arrives. The bench first sets the shared-vector pins' flags one at a time. It withholds the acknowledge for a few cycles, then masks one pin, and only then issues the end-of-interrupt. This shows that every matching flag clears in the same cycle, that the edge pin is untouched, and that the unmasked level pin is requested again straight away.

// File: rtl/irq_trk_pkg.sv
`timescale 1ns/1ps
package irq_trk_pkg;
  typedef struct packed {
    logic pol;
    logic lvl;
    logic mask;
  } pin_cfg_t;
endpackage

// File: rtl/irq_pin_cell.sv
`timescale 1ns/1ps
module irq_pin_cell
  import irq_trk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     raw_i,
  input  pin_cfg_t cfg_i,
  input  logic     grant_i,
  input  logic     ack_i,
  input  logic     eoi_hit_i,
  input  logic     reservice_i,
  output logic     want_o,
  output logic     irr_o,
  output logic     remote_o
);
  logic eff, eff_q, irr_q, rem_q, irr_d, rem_d, rise;

  assign eff  = raw_i ^ cfg_i.pol;
  assign rise = eff & ~eff_q;

  // edge pins: servicing (granted or masked) drops the request
  always_comb begin
    if (cfg_i.lvl) irr_d = eff;
    else           irr_d = eff & (rise | (irr_q & ~grant_i & ~cfg_i.mask));
  end

  always_comb begin
    if (!cfg_i.lvl)                  rem_d = 1'b0;
    else if (grant_i && ack_i)       rem_d = 1'b1;
    else if (eoi_hit_i || reservice_i) rem_d = 1'b0;
    else                             rem_d = rem_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= 1'b0;
      irr_q <= 1'b0;
      rem_q <= 1'b0;
    end else begin
      eff_q <= eff;
      irr_q <= irr_d;
      rem_q <= rem_d;
    end
  end

  assign want_o   = irr_q & ~cfg_i.mask & (~cfg_i.lvl | ~rem_q);
  assign irr_o    = irr_q;
  assign remote_o = rem_q;
endmodule

// File: rtl/irq_eoi_match.sv
`timescale 1ns/1ps
module irq_eoi_match #(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8
) (
  input  logic [N_PINS*VEC_W-1:0] vector_i,
  input  logic                    eoi_valid_i,
  input  logic [VEC_W-1:0]        eoi_vector_i,
  output logic [N_PINS-1:0]       hit_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_cmp
    assign hit_o[g] = eoi_valid_i && (vector_i[g*VEC_W +: VEC_W] == eoi_vector_i);
  end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int N_PINS = 8,
  localparam int IDX_W = $clog2(N_PINS)
) (
  input  logic [N_PINS-1:0] want_i,
  output logic [N_PINS-1:0] grant_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_PINS - 1; i >= 0; i--) begin
      if (want_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |want_i;
  assign grant_o = any_o ? (N_PINS'(1) << idx_o) : '0;
endmodule

// File: rtl/irq_pin_tracker.sv
`timescale 1ns/1ps
module irq_pin_tracker
  import irq_trk_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PINS-1:0]           level_i,
  input  logic [N_PINS-1:0]           polarity_i,
  input  logic [N_PINS-1:0]           lvl_trig_i,
  input  logic [N_PINS-1:0]           mask_i,
  input  logic [N_PINS*VEC_W-1:0]     vector_i,
  input  logic [N_PINS-1:0]           reservice_i,
  input  logic                        eoi_valid_i,
  input  logic [VEC_W-1:0]            eoi_vector_i,
  input  logic                        deliv_ack_i,
  output logic                        req_valid_o,
  output logic [$clog2(N_PINS)-1:0]   req_pin_o,
  output logic [VEC_W-1:0]            req_vector_o,
  output logic [N_PINS-1:0]           irr_o,
  output logic [N_PINS-1:0]           remote_o
);
  logic [N_PINS-1:0] want, grant, eoi_hit;

  irq_eoi_match #(.N_PINS(N_PINS), .VEC_W(VEC_W)) u_match (
    .vector_i    (vector_i),
    .eoi_valid_i (eoi_valid_i),
    .eoi_vector_i(eoi_vector_i),
    .hit_o       (eoi_hit)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{pol: polarity_i[g], lvl: lvl_trig_i[g], mask: mask_i[g]};
    irq_pin_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .raw_i      (level_i[g]),
      .cfg_i      (cfg),
      .grant_i    (grant[g]),
      .ack_i      (deliv_ack_i),
      .eoi_hit_i  (eoi_hit[g]),
      .reservice_i(reservice_i[g]),
      .want_o     (want[g]),
      .irr_o      (irr_o[g]),
      .remote_o   (remote_o[g])
    );
  end

  irq_prio_pick #(.N_PINS(N_PINS)) u_pick (
    .want_i (want),
    .grant_o(grant),
    .idx_o  (req_pin_o),
    .any_o  (req_valid_o)
  );

  assign req_vector_o = vector_i[req_pin_o*VEC_W +: VEC_W];
endmodule

// File: rtl/irq_pin_tracker_chk.sv
`timescale 1ns/1ps
module irq_pin_tracker_chk #(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_PINS-1:0]           level_i,
  input logic [N_PINS-1:0]           polarity_i,
  input logic [N_PINS-1:0]           lvl_trig_i,
  input logic [N_PINS-1:0]           mask_i,
  input logic [N_PINS*VEC_W-1:0]     vector_i,
  input logic [N_PINS-1:0]           reservice_i,
  input logic                        eoi_valid_i,
  input logic [VEC_W-1:0]            eoi_vector_i,
  input logic                        deliv_ack_i,
  input logic                        req_valid_o,
  input logic [$clog2(N_PINS)-1:0]   req_pin_o,
  input logic [VEC_W-1:0]            req_vector_o,
  input logic [N_PINS-1:0]           irr_o,
  input logic [N_PINS-1:0]           remote_o
);
  logic [N_PINS-1:0] eligible, below;
  assign eligible = irr_o & ~mask_i & (~lvl_trig_i | ~remote_o);
  assign below    = (N_PINS'(1) << req_pin_o) - N_PINS'(1);

  p_masked_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !mask_i[req_pin_o]);

  p_lowest_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ((eligible & below) == '0));

  p_no_req_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && lvl_trig_i[req_pin_o]) |-> !remote_o[req_pin_o]);

  p_ack_sets_remote_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && deliv_ack_i && lvl_trig_i[req_pin_o]) |=> remote_o[$past(req_pin_o)]);

  p_edge_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !lvl_trig_i[req_pin_o]) |=> !irr_o[$past(req_pin_o)]);

  p_edge_no_remote_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((remote_o & ~$past(lvl_trig_i)) == '0));

  p_idle_when_none_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eligible == '0) |-> !req_valid_o);
endmodule

bind irq_pin_tracker irq_pin_tracker_chk #(.N_PINS(N_PINS), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_pin_tracker_bench.sv
`timescale 1ns/1ps
module irq_pin_tracker_bench;
  localparam int N = 8;
  localparam int VW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] lvl = '0, pol = '0, trg = '0, msk = '1, rsv = '0;
  logic [N*VW-1:0] vec;
  logic eoi_v = 1'b0, ack = 1'b0;
  logic [VW-1:0] eoi_vec = '0;

  logic req_valid;
  logic [IW-1:0] req_pin;
  logic [VW-1:0] req_vec;
  logic [N-1:0] irr, remote;

  irq_pin_tracker #(.N_PINS(N), .VEC_W(VW)) u_irq_pin_tracker (
    .clk_i(clk), .rst_ni(rst_n), .level_i(lvl), .polarity_i(pol),
    .lvl_trig_i(trg), .mask_i(msk), .vector_i(vec), .reservice_i(rsv),
    .eoi_valid_i(eoi_v), .eoi_vector_i(eoi_vec), .deliv_ack_i(ack),
    .req_valid_o(req_valid), .req_pin_o(req_pin), .req_vector_o(req_vec),
    .irr_o(irr), .remote_o(remote)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [N-1:0] irr_m = '0, rem_m = '0, effq_m = '0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int pick();
    for (int i = 0; i < N; i++)
      if (irr_m[i] && !msk[i] && (!trg[i] || !rem_m[i])) return i;
    return -1;
  endfunction

  // caller sets inputs at a falling edge; returns at the next falling edge
  task automatic cyc(string tag);
    int g;
    logic [N-1:0] eff;
    #2;
    g = pick();
    chk(tag, "req_valid", 64'(req_valid), 64'(g >= 0));
    if (g >= 0) begin
      chk(tag, "req_pin", 64'(req_pin), 64'(g));
      chk(tag, "req_vector", 64'(req_vec), 64'(vec[g*VW +: VW]));
    end
    chk(tag, "irr", 64'(irr), 64'(irr_m));
    chk(tag, "remote", 64'(remote), 64'(rem_m));
    @(posedge clk);
    eff = lvl ^ pol;
    for (int i = 0; i < N; i++) begin
      if (trg[i]) begin
        irr_m[i] = eff[i];
        if (g == i && ack) rem_m[i] = 1'b1;
        else if (rsv[i] || (eoi_v && vec[i*VW +: VW] == eoi_vec)) rem_m[i] = 1'b0;
      end else begin
        rem_m[i] = 1'b0;
        if (!eff[i]) irr_m[i] = 1'b0;
        else if (!effq_m[i]) irr_m[i] = 1'b1;
        else if (g == i || msk[i]) irr_m[i] = 1'b0;
      end
    end
    effq_m = eff;
    @(negedge clk);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) cyc(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) vec[i*VW +: VW] = VW'(8'h20 + i);
    vec[5*VW +: VW] = 8'h22;
    vec[7*VW +: VW] = 8'h22;
    trg = 8'b0110_0111;
    repeat (3) @(negedge clk);
    chk("R1", "irr in reset", 64'(irr), 64'd0);
    chk("R1", "remote in reset", 64'(remote), 64'd0);
    chk("R1", "req_valid in reset", 64'(req_valid), 64'd0);
    rst_n = 1'b1;
    run(2, "R1");

    // R2 / R11: polarity on a masked level pin
    lvl[1] = 1'b1; run(2, "R2");
    pol[1] = 1'b1; run(2, "R11");
    lvl[1] = 1'b0; run(2, "R2");
    pol[1] = 1'b0; run(2, "R11");

    // R3 / R4: edge pin 3 unmasked with ack, edge pin 4 masked
    msk[3] = 1'b0; ack = 1'b1;
    lvl[3] = 1'b1; run(4, "R3");
    lvl[4] = 1'b1; run(3, "R4");
    lvl[3] = 1'b0; run(1, "R11");
    ack = 1'b0; lvl[3] = 1'b1; run(3, "R4");
    lvl[3] = 1'b0; lvl[4] = 1'b0; run(1, "R3");

    // R6 / R7: level pin 0 requested without then with ack
    msk[0] = 1'b0; lvl[0] = 1'b1; run(4, "R7");
    ack = 1'b1; run(3, "R6");

    // R10: several pins together, lowest index first
    msk[2] = 1'b0; msk[5] = 1'b0; msk[6] = 1'b0; msk[7] = 1'b0;
    lvl[2] = 1'b1; lvl[5] = 1'b1; lvl[6] = 1'b1; lvl[7] = 1'b1; lvl[3] = 1'b1;
    ack = 1'b0; run(3, "R10");
    ack = 1'b1; run(6, "R10");

    // R8 / R5: shared-vector EOI, pin 5 masked holding its flag
    msk[5] = 1'b1; run(2, "R5");
    eoi_vec = 8'h22; eoi_v = 1'b1; ack = 1'b0; run(1, "R8");
    eoi_v = 1'b0; run(3, "R8");
    ack = 1'b1; run(2, "R8");
    eoi_vec = 8'h30; eoi_v = 1'b1; run(1, "R8");
    eoi_v = 1'b0; run(1, "R8");

    // R9: reservice on pin 6
    rsv[6] = 1'b1; ack = 1'b0; run(1, "R9");
    rsv[6] = 1'b0; run(2, "R9");
    ack = 1'b1; run(2, "R9");
    msk[5] = 1'b0; rsv[5] = 1'b1; run(1, "R5");
    rsv[5] = 1'b0; run(3, "R9");

    // R11: drop everything
    lvl = '0; run(3, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule